// File: doc/BRIEF.md
# Strap-Selected Serial Register Write Port

This block is the write side of a device's control port. A host sends 16-bit control words over a serial link. Each word carries a 7-bit register address in its upper seven bits and a 9-bit register value in its lower nine bits. For every accepted word the block emits a one-cycle write strobe with that address and value, in the system clock domain. Every register is 9 bits wide, so each write replaces a whole register.

The block supports two serial protocols, and a strap pin chooses between them. A fixed number of system clocks after reset is released, the block samples the protocol-select strap and the chip-select pin once and holds both values. With the protocol strap low, the port runs as a 3-wire slave. Chip select frames each word, data is taken on the rising serial clock, and the word is committed when chip select rises after exactly sixteen bits. With the protocol strap high, the port runs as a 2-wire bus slave. It detects start and stop conditions and answers device address 0011010 if the held chip-select value is low, or 0011011 if it is high. It acknowledges the address byte and two data bytes by pulling its data line low.

After the sample, the block raises flags that free the strap pins for general-purpose use. The protocol-select pin is always freed. The chip-select pin is freed only in 2-wire mode. All serial pins pass through two-flop synchronisers before any decoding.

Top module: `serial_cfg_port`

## Requirements
- R1: `modeGpioFree` is 0 out of reset and rises exactly STRAP_DELAY clock edges after reset release. `csGpioFree` rises on the same edge only if `modePin` was high at the sample. Neither flag falls again until the next reset. No write strobe occurs before the sample.
- R2: A sampled `modePin` of 0 selects 3-wire operation and 1 selects 2-wire operation. After the sample, changes on `modePin` and `csPin` leave the protocol and the device address unchanged until the next reset.
- R3: A control word is shifted in most significant bit first, one bit per rising edge of `sclkPin`. Word bits 15..9 appear on `wrAddr` and bits 8..0 appear on `wrData`.
- R4: In 3-wire mode, bits are taken only while `csPin` is low. A rising `csPin` after exactly 16 bits produces the write strobe 3 clock edges after the `csPin` change.
- R5: In 3-wire mode, a frame of any bit count other than 16 produces no strobe and leaves `wrAddr`/`wrData` unchanged.
- R6: In 2-wire mode, a start condition (SDA falling while SCL is high) followed by address byte {0011010 or 0011011 as chosen by the held chip-select strap, direction bit 0} is acknowledged. `sdaOe` goes high from the falling SCL after the 8th bit until the falling SCL after the 9th bit.
- R7: In 2-wire mode, after an acknowledged address, two data bytes are each acknowledged. The first holds word bits 15..8 and the second holds bits 7..0. The strobe follows 4 clock edges after the SCL rise of the last data bit.
- R8: In 2-wire mode, a mismatched device address or a direction bit of 1 gets no acknowledge and no strobe. The port ignores all later bytes until the next start condition.
- R9: `wrStrobe` is high for one clock per accepted word. Between strobes, `wrAddr` and `wrData` hold their values.
- R10: In 2-wire mode, a stop condition (SDA rising while SCL is high) before the second data byte is complete aborts the transfer with no strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| modePin | input | 1 | Protocol-select strap, sampled once after reset |
| csPin | input | 1 | 3-wire chip select; in 2-wire mode, strap choosing the device address |
| sclkPin | input | 1 | Serial clock (3-wire clock or 2-wire SCL) |
| sdaIn | input | 1 | Serial data in (3-wire data or 2-wire SDA as seen on the bus) |
| sdaOe | output | 1 | Pull SDA low (2-wire acknowledge) |
| wrStrobe | output | 1 | One-cycle register write pulse |
| wrAddr | output | 7 | Register address of the write |
| wrData | output | 9 | Register value of the write |
| modeGpioFree | output | 1 | Protocol-select pin free for general use |
| csGpioFree | output | 1 | Chip-select pin free for general use |

## Verification
Every pin change takes two synchroniser edges before it can be decoded. A 3-wire commit therefore registers its strobe on the third clock edge after chip select rises. A 2-wire commit needs one more edge, because the bit counter must first register the last bit, so it lands on the fourth edge after the last SCL rise. The acknowledge drive changes on the third edge after an SCL fall. The bench drives pins just after a falling clock edge and records the due cycle of each expected write. On every clock it compares the strobe, address and data against that queue, so a strobe that is early, late, missing or extra is caught. Pin changes are spaced several clocks apart, and acknowledge levels are sampled well after their due edge and well before the next SCL change.

// File: rtl/serial_cfg_pkg.sv
package serial_cfg_pkg;

  // Strobes from the control FSMs to the shift datapath
  typedef struct packed {
    logic shift;     // take one serial bit
    logic clearCnt;  // restart the bit count
    logic commit;    // present the assembled word
  } dpCtl_t;

  typedef enum logic [2:0] {
    TW_IDLE,
    TW_ADDR,
    TW_DATA_HI,
    TW_DATA_LO,
    TW_ACK_WAIT,
    TW_ACK_DRIVE,
    TW_IGNORE
  } twState_t;

endpackage

// File: rtl/serial_cfg_sync.sv
module serial_cfg_sync #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  for (genvar g = 0; g < WIDTH; g++) begin : gSync
    logic stage1;
    logic stage2;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        stage1 <= 1'b0;
        stage2 <= 1'b0;
      end else begin
        stage1 <= asyncIn[g];
        stage2 <= stage1;
      end
    end
    assign syncOut[g] = stage2;
  end

endmodule

// File: rtl/serial_cfg_dp.sv
module serial_cfg_dp
  import serial_cfg_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 9,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic              bitIn,
  output logic [CNT_W-1:0]  bitCnt,
  output logic [7:0]        rxByte,
  output logic              wrStrobe,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [DATA_W-1:0] wrData
);

  localparam int WORD_W = ADDR_W + DATA_W;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [WORD_W-1:0] shiftReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      bitCnt   <= '0;
    end else begin
      if (ctl.shift) shiftReg <= {shiftReg[WORD_W-2:0], bitIn};
      if (ctl.clearCnt) bitCnt <= '0;
      else if (ctl.shift && bitCnt != CNT_MAX) bitCnt <= bitCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrStrobe <= 1'b0;
      wrAddr   <= '0;
      wrData   <= '0;
    end else begin
      wrStrobe <= ctl.commit;
      if (ctl.commit) begin
        wrAddr <= shiftReg[WORD_W-1:DATA_W];
        wrData <= shiftReg[DATA_W-1:0];
      end
    end
  end

  assign rxByte = shiftReg[7:0];

endmodule

// File: rtl/serial_cfg_ctrl.sv
module serial_cfg_ctrl
  import serial_cfg_pkg::*;
#(
  parameter int         STRAP_DELAY   = 16,
  parameter int         WORD_W        = 16,
  parameter int         CNT_W         = 5,
  parameter logic [6:0] DEV_ADDR_BASE = 7'b0011010
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             modeS,
  input  logic             csS,
  input  logic             sclS,
  input  logic             sdaS,
  input  logic [CNT_W-1:0] bitCnt,
  input  logic [7:0]       rxByte,
  output dpCtl_t           ctl,
  output logic             sdaOe,
  output logic             modeFree,
  output logic             csFree
);

  localparam int SD_W = $clog2(STRAP_DELAY + 1);
  localparam logic [CNT_W-1:0] BYTE_CNT = CNT_W'(8);
  localparam logic [CNT_W-1:0] WORD_CNT = CNT_W'(WORD_W);

  logic [SD_W-1:0] strapCnt;
  logic strapDone, twoWire, addrSel;
  logic sclD, sdaD, csD;
  twState_t twState, twStateN, twNext, twNextN;
  logic oeN;

  // Power-up strap capture after a settling delay
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      strapCnt  <= '0;
      strapDone <= 1'b0;
      twoWire   <= 1'b0;
      addrSel   <= 1'b0;
    end else if (!strapDone) begin
      if (strapCnt == SD_W'(STRAP_DELAY - 1)) begin
        strapDone <= 1'b1;
        twoWire   <= modeS;
        addrSel   <= csS;
      end else begin
        strapCnt <= strapCnt + 1'b1;
      end
    end
  end

  // Edge history of the synchronised pins
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclD <= 1'b0;
      sdaD <= 1'b0;
      csD  <= 1'b0;
    end else begin
      sclD <= sclS;
      sdaD <= sdaS;
      csD  <= csS;
    end
  end

  logic sclRise, sclFall, sdaRise, sdaFall, csRise;
  logic startCond, stopCond, byteDone, addrHit;
  logic [6:0] devAddr;

  assign sclRise   = sclS & ~sclD;
  assign sclFall   = ~sclS & sclD;
  assign sdaRise   = sdaS & ~sdaD;
  assign sdaFall   = ~sdaS & sdaD;
  assign csRise    = csS & ~csD;
  assign startCond = sdaFall & sclS;
  assign stopCond  = sdaRise & sclS;
  assign byteDone  = (bitCnt == BYTE_CNT);
  assign devAddr   = {DEV_ADDR_BASE[6:1], addrSel};
  assign addrHit   = (rxByte == {devAddr, 1'b0});

  always_comb begin
    ctl      = '0;
    twStateN = twState;
    twNextN  = twNext;
    oeN      = sdaOe;
    if (strapDone && !twoWire) begin
      // 3-wire: chip select frames the word
      ctl.shift    = sclRise & ~csS;
      ctl.clearCnt = csS;
      ctl.commit   = csRise & (bitCnt == WORD_CNT);
    end else if (strapDone) begin
      if (startCond) begin
        twStateN     = TW_ADDR;
        ctl.clearCnt = 1'b1;
        oeN          = 1'b0;
      end else if (stopCond) begin
        twStateN = TW_IDLE;
        oeN      = 1'b0;
      end else begin
        unique case (twState)
          TW_ADDR: begin
            ctl.shift = sclRise;
            if (byteDone) begin
              if (addrHit) begin
                twStateN = TW_ACK_WAIT;
                twNextN  = TW_DATA_HI;
              end else begin
                twStateN = TW_IGNORE;
              end
            end
          end
          TW_DATA_HI: begin
            ctl.shift = sclRise;
            if (byteDone) begin
              twStateN = TW_ACK_WAIT;
              twNextN  = TW_DATA_LO;
            end
          end
          TW_DATA_LO: begin
            ctl.shift = sclRise;
            if (byteDone) begin
              ctl.commit = 1'b1;
              twStateN   = TW_ACK_WAIT;
              twNextN    = TW_IGNORE;
            end
          end
          TW_ACK_WAIT: begin
            if (sclFall) begin
              oeN      = 1'b1;
              twStateN = TW_ACK_DRIVE;
            end
          end
          TW_ACK_DRIVE: begin
            if (sclFall) begin
              oeN          = 1'b0;
              twStateN     = twNext;
              ctl.clearCnt = 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      twState <= TW_IDLE;
      twNext  <= TW_IDLE;
      sdaOe   <= 1'b0;
    end else begin
      twState <= twStateN;
      twNext  <= twNextN;
      sdaOe   <= oeN;
    end
  end

  assign modeFree = strapDone;
  assign csFree   = strapDone & twoWire;

endmodule

// File: rtl/serial_cfg_port.sv
module serial_cfg_port
  import serial_cfg_pkg::*;
#(
  parameter int         ADDR_W        = 7,
  parameter int         DATA_W        = 9,
  parameter int         STRAP_DELAY   = 16,
  parameter logic [6:0] DEV_ADDR_BASE = 7'b0011010
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              modePin,
  input  logic              csPin,
  input  logic              sclkPin,
  input  logic              sdaIn,
  output logic              sdaOe,
  output logic              wrStrobe,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [DATA_W-1:0] wrData,
  output logic              modeGpioFree,
  output logic              csGpioFree
);

  localparam int WORD_W = ADDR_W + DATA_W;
  localparam int CNT_W  = $clog2(WORD_W + 2);

  logic [3:0] pinSync;
  dpCtl_t ctl;
  logic [CNT_W-1:0] bitCnt;
  logic [7:0] rxByte;

  serial_cfg_sync #(.WIDTH(4)) u_sync (
    .clk(clk), .rstN(rstN),
    .asyncIn({modePin, csPin, sclkPin, sdaIn}),
    .syncOut(pinSync)
  );

  serial_cfg_ctrl #(
    .STRAP_DELAY(STRAP_DELAY), .WORD_W(WORD_W),
    .CNT_W(CNT_W), .DEV_ADDR_BASE(DEV_ADDR_BASE)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .modeS(pinSync[3]), .csS(pinSync[2]), .sclS(pinSync[1]), .sdaS(pinSync[0]),
    .bitCnt(bitCnt), .rxByte(rxByte),
    .ctl(ctl), .sdaOe(sdaOe),
    .modeFree(modeGpioFree), .csFree(csGpioFree)
  );

  serial_cfg_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN),
    .ctl(ctl), .bitIn(pinSync[0]),
    .bitCnt(bitCnt), .rxByte(rxByte),
    .wrStrobe(wrStrobe), .wrAddr(wrAddr), .wrData(wrData)
  );

endmodule

// File: rtl/serial_cfg_chk.sv
module serial_cfg_chk #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 9
) (
  input logic              clk,
  input logic              rstN,
  input logic              sdaOe,
  input logic              wrStrobe,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [DATA_W-1:0] wrData,
  input logic              modeGpioFree,
  input logic              csGpioFree
);

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe |=> !wrStrobe);                                         // R9
  AST_OUTPUTS_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !wrStrobe |-> ($stable(wrAddr) && $stable(wrData)));             // R9
  AST_NO_EARLY_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe |-> modeGpioFree);                                      // R1
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    modeGpioFree |=> modeGpioFree);                                  // R1
  AST_CS_FLAG_AFTER_SAMPLE: assert property (@(posedge clk) disable iff (!rstN)
    csGpioFree |-> modeGpioFree);                                    // R1
  AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    modeGpioFree |=> $stable(csGpioFree));                           // R2
  AST_ACK_TWO_WIRE_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    sdaOe |-> csGpioFree);                                           // R6

endmodule

bind serial_cfg_port serial_cfg_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/test_serial_cfg_port.sv
module test_serial_cfg_port;

  localparam int SD = 16;
  localparam int H  = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic modePin = 1'b0, csPin = 1'b1, sclkPin = 1'b0, sdaDrv = 1'b1;
  logic sdaBus, sdaOe, wrStrobe, modeGpioFree, csGpioFree;
  logic [6:0] wrAddr;
  logic [8:0] wrData;

  assign sdaBus = sdaDrv & ~sdaOe;

  serial_cfg_port #(.STRAP_DELAY(SD)) i_serial_cfg_port (
    .clk(clk), .rstN(rstN), .modePin(modePin), .csPin(csPin),
    .sclkPin(sclkPin), .sdaIn(sdaBus), .sdaOe(sdaOe),
    .wrStrobe(wrStrobe), .wrAddr(wrAddr), .wrData(wrData),
    .modeGpioFree(modeGpioFree), .csGpioFree(csGpioFree)
  );

  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int vectors = 0, miscompares = 0;
  bit finished = 0;
  string curTag = "R9";
  int dueQ[$];
  logic [6:0] aQ[$];
  logic [8:0] dQ[$];
  string tQ[$];
  logic [6:0] lastA = '0;
  logic [8:0] lastD = '0;

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  // Reference: expected writes with their due cycles, compared every clock
  always @(negedge clk) begin
    if (rstN && !finished) begin
      bit expS;
      expS = (dueQ.size() > 0) && (dueQ[0] == cyc);
      chk(wrStrobe === expS, expS ? tQ[0] : curTag, "wrStrobe", int'(wrStrobe), int'(expS));
      if (expS) begin
        chk(wrAddr === aQ[0], tQ[0], "wrAddr", int'(wrAddr), int'(aQ[0]));
        chk(wrData === dQ[0], tQ[0], "wrData", int'(wrData), int'(dQ[0]));
        lastA = aQ[0];
        lastD = dQ[0];
        void'(dueQ.pop_front()); void'(aQ.pop_front());
        void'(dQ.pop_front());   void'(tQ.pop_front());
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expectWrite(input int lat, input logic [15:0] w, input string tag);
    dueQ.push_back(cyc + lat);
    aQ.push_back(w[15:9]);
    dQ.push_back(w[8:0]);
    tQ.push_back(tag);
  endtask

  task automatic doReset(input logic m, input logic c);
    @(negedge clk);
    rstN = 1'b0;
    modePin = m; csPin = c; sdaDrv = 1'b1; sclkPin = m;
    dueQ.delete(); aQ.delete(); dQ.delete(); tQ.delete();
    lastA = '0; lastD = '0;
    idle(3);
    chk(!wrStrobe && !modeGpioFree && !csGpioFree && !sdaOe, "R1", "reset state",
        int'({wrStrobe, modeGpioFree, csGpioFree, sdaOe}), 0);
    rstN = 1'b1;
    idle(SD - 1);
    chk(modeGpioFree == 1'b0, "R1", "modeGpioFree before sample", int'(modeGpioFree), 0);
    idle(1);
    chk(modeGpioFree == 1'b1, "R1", "modeGpioFree at sample", int'(modeGpioFree), 1);
    chk(csGpioFree == m, "R1", "csGpioFree at sample", int'(csGpioFree), int'(m));
    idle(2);
  endtask

  // 3-wire frame of n bits taken from the top of w
  task automatic spiFrame(input logic [31:0] w, input int n, input string tag);
    curTag = tag;
    csPin = 1'b0; idle(H);
    for (int i = n - 1; i >= 0; i--) begin
      sdaDrv = w[i]; idle(H);
      sclkPin = 1'b1; idle(H);
      sclkPin = 1'b0;
    end
    idle(H);
    csPin = 1'b1;
    if (n == 16) expectWrite(3, w[15:0], tag);
    idle(3 * H);
  endtask

  task automatic twStart();
    sdaDrv = 1'b1; sclkPin = 1'b1; idle(H);
    sdaDrv = 1'b0; idle(H);
    sclkPin = 1'b0; idle(H);
  endtask

  task automatic twStop();
    sdaDrv = 1'b0; idle(H);
    sclkPin = 1'b1; idle(H);
    sdaDrv = 1'b1; idle(H);
  endtask

  task automatic twByte(input logic [7:0] b, input bit expAck, input bit last,
                        input logic [15:0] w, input string tag);
    for (int i = 7; i >= 0; i--) begin
      sdaDrv = b[i]; idle(H);
      sclkPin = 1'b1;
      if (i == 0 && last) expectWrite(4, w, tag);
      idle(H);
      sclkPin = 1'b0; idle(H);
    end
    sdaDrv = 1'b1; idle(H);
    chk(sdaOe == expAck, tag, "ack drive", int'(sdaOe), int'(expAck));
    sclkPin = 1'b1; idle(H);
    sclkPin = 1'b0; idle(H);
    chk(sdaOe == 1'b0, tag, "ack release", int'(sdaOe), 0);
  endtask

  task automatic twXfer(input logic [6:0] dev, input bit rd, input logic [15:0] w,
                        input bit good, input int nData, input string tag);
    curTag = tag;
    twStart();
    twByte({dev, rd}, good, 1'b0, w, tag);
    for (int k = 0; k < nData; k++)
      twByte(k == 0 ? w[15:8] : w[7:0], good, good && (k == 1), w, tag);
    twStop();
    idle(2 * H);
  endtask

  initial begin
    // 3-wire session
    doReset(1'b0, 1'b1);
    spiFrame(32'hB5A7, 16, "R3");
    spiFrame(32'h0001, 16, "R4");
    spiFrame(32'hFFFF, 16, "R4");
    spiFrame(32'h4C3A, 16, "R3");
    spiFrame(32'h12A5, 15, "R5");
    chk(wrAddr == lastA && wrData == lastD, "R5", "hold after short frame",
        int'({wrAddr, wrData}), int'({lastA, lastD}));
    spiFrame(32'h1_2345, 17, "R5");
    chk(wrAddr == lastA && wrData == lastD, "R5", "hold after long frame",
        int'({wrAddr, wrData}), int'({lastA, lastD}));
    modePin = 1'b1; idle(H);
    spiFrame(32'h9E01, 16, "R2");
    chk(csGpioFree == 1'b0, "R2", "mode held after strap change", int'(csGpioFree), 0);
    modePin = 1'b0;

    // 2-wire session, address strap low
    doReset(1'b1, 1'b0);
    twXfer(7'b0011010, 1'b0, 16'hA55A, 1'b1, 2, "R6");
    twXfer(7'b0011010, 1'b0, 16'h0380, 1'b1, 2, "R7");
    twXfer(7'b0011011, 1'b0, 16'h7777, 1'b0, 2, "R8");
    twXfer(7'b0011010, 1'b1, 16'h6666, 1'b0, 2, "R8");
    curTag = "R10";
    twStart();
    twByte({7'b0011010, 1'b0}, 1'b1, 1'b0, 16'h1234, "R10");
    twByte(8'h12, 1'b1, 1'b0, 16'h1234, "R10");
    twStop();
    idle(2 * H);
    chk(wrAddr == lastA && wrData == lastD, "R10", "hold after stop abort",
        int'({wrAddr, wrData}), int'({lastA, lastD}));
    csPin = 1'b1; modePin = 1'b0; idle(H);
    twXfer(7'b0011010, 1'b0, 16'hC0DE, 1'b1, 2, "R2");

    // 2-wire session, address strap high
    doReset(1'b1, 1'b1);
    twXfer(7'b0011010, 1'b0, 16'h5555, 1'b0, 2, "R8");
    twXfer(7'b0011011, 1'b0, 16'h3C3C, 1'b1, 2, "R6");
    csPin = 1'b0; idle(H);
    twXfer(7'b0011011, 1'b0, 16'hFEED, 1'b1, 2, "R7");

    idle(10);
    chk(dueQ.size() == 0, "R9", "all expected writes seen", dueQ.size(), 0);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      miscompares++;
      $display("FAIL R9 watchdog act=%0d exp=%0d", cyc, 150000);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule